// File: doc/BRIEF.md
# Write-Masked Pin Function and Pull Configuration Register File

This block stores the per-pin configuration of a multi-bank I/O ring: a 2-bit function-select code for every pin and a pull-disable bit for every pin. A simple single-cycle register bus reads and writes the storage. The block drives two flat output vectors: the function code of every pin, and the pull-enable state of every pin. Selecting which pad signal a function code routes to is done elsewhere.

Every configuration register is 32 bits wide. Only its lower 16 bits hold state. The upper 16 bits of a written word act as a per-bit write enable for the lower 16 bits. Software can therefore retarget one pin's function or pull without first reading the register back, and two agents that touch different pins of the same register cannot undo each other's update.

Function registers hold 8 pins each, and every bank owns a run of consecutive function registers. Pull registers hold 16 pins each, also in consecutive runs per bank. The pull run starts at a fixed offset above the function run. Any other address reads as zero and ignores writes.

Top module: `pin_cfg_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, every function field becomes 0 (plain GPIO), every pull-disable bit becomes 0 (so every `pin_pull_en` bit is 1), and `rsp_valid` becomes 0. After reset, every mapped register reads as zero.
- R2: A write to a mapped register updates lower bit k only when written bit k+16 is 1. Every lower bit whose enable is 0 keeps its previous value.
- R3: The function field of bank b, pin p lives at byte address MUX_BASE + b*0x10 + (p/8)*4, in bits [2*(p%8)+1 : 2*(p%8)]. On `pin_func` it appears at bits [2*(32*b+p)+1 : 2*(32*b+p)].
- R4: The pull-disable bit of bank b, pin p lives at byte address 0x118 + b*8 + (p/16)*4, in bit p%16. A stored 1 drives `pin_pull_en[32*b+p]` to 0, and a stored 0 drives it to 1.
- R5: Pull registers follow the same upper-half write-enable rule as function registers.
- R6: A read request (`req_en`=1, `req_write`=0) sets `rsp_valid` to 1 in the following cycle. In that same cycle `rsp_rdata` carries the register's stored 16 bits in bits [15:0] and zero in bits [31:16]. In a cycle after a non-read, `rsp_valid` is 0.
- R7: An address that is not 4-byte aligned, or that lies outside both register runs, reads as zero and ignores writes. This includes the gap between 0x40 and 0x118 and every address from 0x138 up.
- R8: A write whose upper 16 bits are all zero changes no output and no stored bit. A cycle without a write request also leaves both output vectors unchanged.
- R9: `pin_func` and `pin_pull_en` show the effect of a write in the cycle right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data; [31:16] enables, [15:0] values |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data; upper half always zero |
| pin_func | output | 256 | 2-bit function code per pin, pin n at [2n+1:2n] |
| pin_pull_en | output | 128 | 1 = default pull active on pin n |

## Verification
Suppose a stored bit is wrong, whether from an ignored write enable, a bad address decode or a stray write into a neighbouring register. The error reaches `pin_func` or `pin_pull_en` in the cycle after the write edge. The bench compares both vectors with its own model on every clock, so it reports the error within one cycle of its cause. It does not wait for a later readback. Decode faults that only touch readback, such as nonzero upper bits or data from an unmapped address, show on `rsp_rdata` one cycle after the read request.

// File: rtl/pin_cfg_pkg.sv
package pin_cfg_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;

  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] old_val,
    input logic [WORD_W-1:0] wword
  );
    logic [HALF_W-1:0] en;
    en = wword[WORD_W-1:HALF_W];
    return (old_val & ~en) | (wword[HALF_W-1:0] & en);
  endfunction
endpackage

// File: rtl/pcfg_addr_decode.sv
module pcfg_addr_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MUX_BASE  = 32'h000,
  parameter int unsigned NUM_MUX   = 16,
  parameter int unsigned PULL_BASE = 32'h118,
  parameter int unsigned NUM_PULL  = 8,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              mux_hit,
  output logic              pull_hit,
  output logic [IDX_W-1:0]  idx
);
  logic [31:0] a32;
  logic [31:0] mux_off;
  logic [31:0] pull_off;
  logic        aligned;

  always_comb begin
    a32      = 32'(addr);
    mux_off  = a32 - 32'(MUX_BASE);
    pull_off = a32 - 32'(PULL_BASE);
    aligned  = (addr[1:0] == 2'b00);
    mux_hit  = aligned && (a32 >= 32'(MUX_BASE)) && (mux_off < 32'(NUM_MUX * 4));
    pull_hit = aligned && (a32 >= 32'(PULL_BASE)) && (pull_off < 32'(NUM_PULL * 4));
    if (mux_hit) idx = mux_off[IDX_W+1:2];
    else         idx = pull_off[IDX_W+1:2];
  end
endmodule

// File: rtl/pcfg_masked_regs.sv
module pcfg_masked_regs
  import pin_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned IDX_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WORD_W-1:0]          wr_word,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [HALF_W-1:0]          rd_val,
  output logic [NUM_REGS*HALF_W-1:0] flat
);
  logic [HALF_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_en && (32'(wr_idx) == g))
        regs[g] <= masked_merge(regs[g], wr_word);
    end
    assign flat[g*HALF_W +: HALF_W] = regs[g];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (32'(rd_idx) == i) rd_val = regs[i];
  end
endmodule

// File: rtl/pin_cfg_regfile.sv
module pin_cfg_regfile
  import pin_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned PINS_PER_BANK = 32,
  parameter int unsigned FUNC_W        = 2,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned MUX_BASE      = 32'h000,
  parameter int unsigned PULL_BASE     = 32'h118
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_en,
  input  logic                                   req_write,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [31:0]                            req_wdata,
  output logic                                   rsp_valid,
  output logic [31:0]                            rsp_rdata,
  output logic [NUM_BANKS*PINS_PER_BANK*FUNC_W-1:0] pin_func,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]        pin_pull_en
);
  localparam int unsigned NUM_PINS      = NUM_BANKS * PINS_PER_BANK;
  localparam int unsigned MUX_PER_BANK  = PINS_PER_BANK * FUNC_W / HALF_W;
  localparam int unsigned PULL_PER_BANK = PINS_PER_BANK / HALF_W;
  localparam int unsigned NUM_MUX       = NUM_BANKS * MUX_PER_BANK;
  localparam int unsigned NUM_PULL      = NUM_BANKS * PULL_PER_BANK;
  localparam int unsigned MAX_REGS      = (NUM_MUX > NUM_PULL) ? NUM_MUX : NUM_PULL;
  localparam int unsigned IDX_W         = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

  logic             mux_hit, pull_hit;
  logic [IDX_W-1:0] idx;
  logic [HALF_W-1:0] mux_rd, pull_rd;
  logic [NUM_MUX*HALF_W-1:0]  mux_flat;
  logic [NUM_PULL*HALF_W-1:0] pull_flat;
  logic wr_go;

  assign wr_go = req_en && req_write;

  pcfg_addr_decode #(
    .ADDR_W(ADDR_W), .MUX_BASE(MUX_BASE), .NUM_MUX(NUM_MUX),
    .PULL_BASE(PULL_BASE), .NUM_PULL(NUM_PULL), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .mux_hit(mux_hit), .pull_hit(pull_hit), .idx(idx)
  );

  pcfg_masked_regs #(.NUM_REGS(NUM_MUX), .IDX_W(IDX_W)) u_mux (
    .clk(clk), .rst(rst), .wr_en(wr_go && mux_hit), .wr_idx(idx),
    .wr_word(req_wdata), .rd_idx(idx), .rd_val(mux_rd), .flat(mux_flat)
  );

  pcfg_masked_regs #(.NUM_REGS(NUM_PULL), .IDX_W(IDX_W)) u_pull (
    .clk(clk), .rst(rst), .wr_en(wr_go && pull_hit), .wr_idx(idx),
    .wr_word(req_wdata), .rd_idx(idx), .rd_val(pull_rd), .flat(pull_flat)
  );

  // Function fields pack contiguously: pin n sits at bits [FUNC_W*n +: FUNC_W].
  assign pin_func    = mux_flat[NUM_PINS*FUNC_W-1:0];
  // A stored 1 disables the pull, so the enable is the inverse.
  assign pin_pull_en = ~pull_flat[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_en && !req_write;
      if (req_en && !req_write) begin
        if (mux_hit)       rsp_rdata <= {16'h0000, mux_rd};
        else if (pull_hit) rsp_rdata <= {16'h0000, pull_rd};
        else               rsp_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pin_cfg_regfile_chk.sv
module pin_cfg_regfile_chk #(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned PINS_PER_BANK = 32,
  parameter int unsigned FUNC_W        = 2,
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned MUX_BASE      = 32'h000,
  parameter int unsigned PULL_BASE     = 32'h118
) (
  input logic                                      clk,
  input logic                                      rst,
  input logic                                      req_en,
  input logic                                      req_write,
  input logic [ADDR_W-1:0]                         req_addr,
  input logic [15:0]                               req_wmask,
  input logic                                      rsp_valid,
  input logic [31:0]                               rsp_rdata,
  input logic [NUM_BANKS*PINS_PER_BANK*FUNC_W-1:0] pin_func,
  input logic [NUM_BANKS*PINS_PER_BANK-1:0]        pin_pull_en
);
  localparam int unsigned MUX_END  = MUX_BASE + NUM_BANKS * PINS_PER_BANK * FUNC_W / 4;
  localparam int unsigned PULL_END = PULL_BASE + NUM_BANKS * PINS_PER_BANK / 4;

  logic in_map;
  always_comb begin
    in_map = (req_addr[1:0] == 2'b00) &&
             (((32'(req_addr) >= 32'(MUX_BASE))  && (32'(req_addr) < 32'(MUX_END))) ||
              ((32'(req_addr) >= 32'(PULL_BASE)) && (32'(req_addr) < 32'(PULL_END))));
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pin_func == '0 && pin_pull_en == '1 && !rsp_valid));

  assert_read_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (req_en && !req_write) |=> rsp_valid);

  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !(req_en && !req_write) |=> !rsp_valid);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[31:16] == 16'h0000));

  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (req_en && !req_write && !in_map) |=> (rsp_rdata == 32'h0));

  assert_unmapped_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_write && !in_map) |=> ($stable(pin_func) && $stable(pin_pull_en)));

  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_write && req_wmask == 16'h0) |=> ($stable(pin_func) && $stable(pin_pull_en)));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !(req_en && req_write) |=> ($stable(pin_func) && $stable(pin_pull_en)));
endmodule

bind pin_cfg_regfile pin_cfg_regfile_chk #(
  .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK), .FUNC_W(FUNC_W),
  .ADDR_W(ADDR_W), .MUX_BASE(MUX_BASE), .PULL_BASE(PULL_BASE)
) u_chk (
  .clk(clk), .rst(rst), .req_en(req_en), .req_write(req_write),
  .req_addr(req_addr), .req_wmask(req_wdata[31:16]),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .pin_func(pin_func), .pin_pull_en(pin_pull_en)
);

// File: tb/pin_cfg_regfile_test.sv
module pin_cfg_regfile_test;
  localparam int NPINS = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_en = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [2*NPINS-1:0] pin_func;
  logic [NPINS-1:0]   pin_pull_en;

  pin_cfg_regfile uut (
    .clk(clk), .rst(rst), .req_en(req_en), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_func(pin_func), .pin_pull_en(pin_pull_en)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model: plain integer arrays indexed by register number.
  int unsigned mux_m [16];
  int unsigned pull_m [8];
  bit          exp_valid = 0;
  int unsigned exp_rdata = 0;

  task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int unsigned model_read(input int unsigned a);
    if (a % 4 != 0) return 0;
    if (a < 32'h40) return mux_m[a/4];
    if (a >= 32'h118 && a < 32'h138) return pull_m[(a-32'h118)/4];
    return 0;
  endfunction

  function automatic int unsigned merge(input int unsigned old, input int unsigned w);
    int unsigned en;
    en = (w >> 16) & 32'hFFFF;
    return (old & ~en & 32'hFFFF) | (w & en);
  endfunction

  task automatic compare_all();
    logic [2*NPINS-1:0] ef;
    logic [NPINS-1:0]   ep;
    for (int n = 0; n < NPINS; n++) begin
      ef[2*n +: 2] = 2'((mux_m[n/8] >> (2*(n%8))) & 3);
      ep[n]        = ((pull_m[n/16] >> (n%16)) & 1) == 0;
    end
    chk("R9 pin_func per clock", 256'(pin_func), 256'(ef));
    chk("R4 pin_pull_en per clock", 256'(pin_pull_en), 256'(ep));
    chk("R6 rsp_valid per clock", 256'(rsp_valid), 256'(exp_valid));
    if (exp_valid) chk("R6 rsp_rdata per clock", 256'(rsp_rdata), 256'(exp_rdata));
  endtask

  task automatic cycle(input bit r, input bit en, input bit wr,
                       input int unsigned a, input int unsigned d);
    @(negedge clk);
    compare_all();
    rst = r; req_en = en; req_write = wr; req_addr = 12'(a); req_wdata = d;
    if (r) begin
      foreach (mux_m[i]) mux_m[i] = 0;
      foreach (pull_m[i]) pull_m[i] = 0;
      exp_valid = 0;
      exp_rdata = 0;
    end else begin
      exp_valid = en && !wr;
      if (en && !wr) exp_rdata = model_read(a);
      if (en && wr && a % 4 == 0) begin
        if (a < 32'h40) mux_m[a/4] = merge(mux_m[a/4], d);
        else if (a >= 32'h118 && a < 32'h138)
          pull_m[(a-32'h118)/4] = merge(pull_m[(a-32'h118)/4], d);
      end
    end
  endtask

  task automatic idle();                                        cycle(0, 0, 0, 0, 0); endtask
  task automatic wr_reg(input int unsigned a, input int unsigned d); cycle(0, 1, 1, a, d); endtask

  task automatic rd_expect(input string tag, input int unsigned a, input int unsigned e);
    cycle(0, 1, 0, a, 0);
    idle();
    chk(tag, 256'(rsp_rdata), 256'(e));
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [2*NPINS-1:0] func_snap;
    logic [NPINS-1:0]   pull_snap;
    lfsr = 32'h1ACE_B00C;
    foreach (mux_m[i]) mux_m[i] = 0;
    foreach (pull_m[i]) pull_m[i] = 0;

    cycle(1, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0);
    idle();
    chk("R1 reset func zero", 256'(pin_func), 256'(0));
    chk("R1 reset pull enabled", 256'(pin_pull_en), {128'h0, {128{1'b1}}});
    rd_expect("R1 reset mux readback", 32'h24, 0);
    rd_expect("R1 reset pull readback", 32'h134, 0);

    // R3: bank 2 pin 13 -> addr 0x24, bits [11:10], global pin 77.
    wr_reg(32'h24, (32'h3 << 26) | (32'h3 << 10));
    idle();
    chk("R3 func of bank2 pin13", 256'(pin_func[2*77 +: 2]), 256'(3));
    chk("R9 neighbour pin untouched", 256'(pin_func[2*76 +: 2]), 256'(0));
    rd_expect("R3 readback 0x24", 32'h24, 32'h0C00);

    // R2: only bit 11 enabled, written 0 -> field becomes 1.
    wr_reg(32'h24, (32'h1 << 27));
    idle();
    chk("R2 partial field update", 256'(pin_func[2*77 +: 2]), 256'(1));
    rd_expect("R2 readback 0x24", 32'h24, 32'h0400);

    // R8: zero enable mask.
    wr_reg(32'h24, 32'h0000_FFFF);
    idle();
    rd_expect("R8 zero mask ignored", 32'h24, 32'h0400);

    // R4: bank 3 pin 20 -> addr 0x134, bit 4, global pin 116.
    wr_reg(32'h134, (32'h1 << 20) | (32'h1 << 4));
    idle();
    chk("R4 pull disabled pin116", 256'(pin_pull_en[116]), 256'(0));
    chk("R4 pull still on pin115", 256'(pin_pull_en[115]), 256'(1));
    rd_expect("R4 readback 0x134", 32'h134, 32'h0010);

    // R5: pull register partial mask.
    wr_reg(32'h118, 32'h00F0_FFFF);
    idle();
    rd_expect("R5 pull masked write", 32'h118, 32'h00F0);
    chk("R5 pull pins 4..7 off", 256'(pin_pull_en[7:0]), 256'(8'h0F));

    // R7: unmapped and misaligned writes ignored, read as zero.
    func_snap = pin_func;
    pull_snap = pin_pull_en;
    wr_reg(32'h40, 32'hFFFF_FFFF);
    wr_reg(32'h114, 32'hFFFF_FFFF);
    wr_reg(32'h138, 32'hFFFF_FFFF);
    wr_reg(32'h26, 32'hFFFF_FFFF);
    wr_reg(32'h11A, 32'hFFFF_FFFF);
    idle();
    chk("R7 func unchanged", 256'(pin_func), 256'(func_snap));
    chk("R7 pull unchanged", 256'(pin_pull_en), 256'(pull_snap));
    rd_expect("R7 read 0x40", 32'h40, 0);
    rd_expect("R7 read 0x138", 32'h138, 0);
    rd_expect("R7 read misaligned 0x26", 32'h26, 0);

    // R6: full-mask pattern into every register, then read back.
    for (int i = 0; i < 16; i++) wr_reg(4*i, 32'hFFFF_0000 | (32'hA5C3 ^ (i * 32'h111)));
    for (int i = 0; i < 8; i++)  wr_reg(32'h118 + 4*i, 32'hFFFF_0000 | (32'h3C5A + i));
    for (int i = 0; i < 16; i++) rd_expect("R6 mux readback", 4*i, (32'hA5C3 ^ (i * 32'h111)) & 32'hFFFF);
    for (int i = 0; i < 8; i++)  rd_expect("R6 pull readback", 32'h118 + 4*i, 32'h3C5A + i);

    // Mixed traffic against the model (per-clock compare covers R2, R5, R9).
    for (int k = 0; k < 600; k++) begin
      int unsigned a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = {lfsr[6], 8'h00} | (32'(lfsr[5:0]) << 2);
      if (lfsr[7] && lfsr[8]) a = a | 1;
      cycle(0, lfsr[9] | lfsr[10], lfsr[11], a, {lfsr[15:0], lfsr[31:16]} ^ lfsr);
    end
    idle();

    // R1: reset mid-run, with a write pending in the same cycle.
    cycle(1, 1, 1, 32'h0, 32'hFFFF_FFFF);
    idle();
    chk("R1 mid-run reset func", 256'(pin_func), 256'(0));
    chk("R1 mid-run reset pull", 256'(pin_pull_en), {128'h0, {128{1'b1}}});
    rd_expect("R1 mid-run reset readback", 32'h0, 0);
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule